// File: doc/BRIEF.md
# Receive Frame Page Writer

This block takes one incoming Ethernet frame and lays it out, one byte per clock, in a single 2 KiB buffer page. The surrounding receive path pulses `start` with the frame length, the CRC handling choice, the receive enable and soft-reset controls, a page-available flag and the frame's precomputed CRC. The block pulls frame bytes through an indexed read port (`frame_idx` out, `frame_byte` back in the same cycle) and drives a byte-write port into the page RAM. It ends each frame with either a one-cycle `done` (the frame is stored and the receive event is raised) or a one-cycle `drop`.

The stored page holds, from offset 0: a 16-bit status word and a 16-bit byte count, both low byte first. These are followed by the payload. The payload is zero-padded to 64 bytes for short frames, or cut to an even length for longer ones. The four CRC bytes come next, unless CRC stripping is selected. The page closes with a two-byte tail. That tail carries either the odd last frame byte and control value 0x60, or a zero byte and control value 0x40.

The controller is a state machine with states IDLE, HEAD (4 header bytes), BODY (payload and padding), CRC (4 bytes, skipped when stripping), TAIL (2 bytes), FIN (done pulse) and DROP (drop pulse). Its transitions are as follows. IDLE goes to DROP on a refused `start` and to HEAD on an accepted `start`. HEAD goes to BODY after its fourth byte. BODY goes to CRC after the last payload byte, or straight to TAIL when CRC is stripped. CRC goes to TAIL after its fourth byte. TAIL goes to FIN after the control byte. FIN and DROP each return to IDLE after one cycle.

Top module: `rx_page_writer`

## Requirements
- R1: A `start` seen while `rx_enable` is low or `soft_reset` is high is refused. `drop` pulses in the cycle after the start edge, and nothing is written.
- R2: With stored length S (64 if the frame length L is below 64, else L rounded down to even), the byte count is S+6, plus 4 when `strip_crc` is low. A frame whose byte count exceeds 2048 is dropped as in R1.
- R3: A `start` with `page_ok` low is dropped as in R1.
- R4: Page bytes 0 and 1 hold the status word, low byte first. Bit 11 is set when L > 1518, and bit 12 is set when L is odd. All other bits are zero.
- R5: Page bytes 2 and 3 hold the byte count from R2, low byte first.
- R6: For L < 64, page bytes 4..67 hold frame bytes 0..L-1, including an odd last byte, followed by zeros up to 64 bytes.
- R7: For L >= 64, page bytes 4..S+3 hold frame bytes 0..S-1.
- R8: When `strip_crc` is low, the 4 bytes after the payload are `crc_value`, least significant byte first. When it is high, no CRC bytes are stored.
- R9: The last two page bytes are frame byte L-1 then 0x60 when L >= 64 and L is odd. Otherwise they are 0x00 then 0x40.
- R10: Writes go to consecutive addresses from 0, one per cycle, starting the cycle after the start edge. The number of writes equals the byte count, and `done` pulses in the cycle after the control byte is written.
- R11: After reset the block is idle, with `busy`, `done`, `drop` and `wr_en` low. `done` and `drop` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| frame_len | input | 12 | Frame length in bytes |
| strip_crc | input | 1 | High: do not store the CRC |
| rx_enable | input | 1 | Receive enable |
| soft_reset | input | 1 | Soft reset active; refuses frames |
| page_ok | input | 1 | A buffer page is allocated for this frame |
| crc_value | input | 32 | Precomputed frame CRC |
| frame_idx | output | 12 | Index of the frame byte wanted |
| frame_byte | input | 8 | Frame byte at `frame_idx` |
| wr_en | output | 1 | Page RAM byte write strobe |
| wr_addr | output | 11 | Page RAM byte address |
| wr_data | output | 8 | Page RAM byte data |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Frame stored; receive event |
| drop | output | 1 | Frame refused |

## Verification
The bench targets the length boundaries at 63/64/65 and at 1518/1519, where a wrong comparison would set the too-long bit early or pad a 64-byte frame. It also covers the 2048-byte page limit with and without CRC: 2038 against 2040 bytes, and 2042 against 2044 bytes. An off-by-one there would either overflow the page or drop a legal frame. Odd short frames check that the odd byte sits before the padding and that the control byte stays 0x40. Odd long frames check that the odd byte lands after the CRC with 0x60, which a design that mixed the two cases would get wrong. Refusal cases confirm that a disabled, soft-reset or pageless start writes nothing at all.

// File: rtl/rx_page_writer_pkg.sv
package rx_page_writer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_CRC,
        ST_TAIL,
        ST_FIN,
        ST_DROP
    } rpw_state_t;

    localparam logic [7:0] CTRL_EVEN = 8'h40;
    localparam logic [7:0] CTRL_ODD  = 8'h60;
    localparam int STAT_BIT_LONG = 11;
    localparam int STAT_BIT_ODD  = 12;
    localparam int HEAD_BYTES = 4;
    localparam int CRC_BYTES  = 4;
    localparam int TAIL_BYTES = 2;
endpackage

// File: rtl/rpw_layout.sv
module rpw_layout #(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_FRAME  = 1518
) (
    input  logic [LEN_W-1:0] len,
    input  logic             strip,
    output logic [LEN_W-1:0] stored,
    output logic [LEN_W:0]   count,
    output logic [15:0]      status,
    output logic             too_big
);
    import rx_page_writer_pkg::*;

    localparam logic [LEN_W:0] OVERHEAD = (LEN_W+1)'(HEAD_BYTES + TAIL_BYTES);
    localparam logic [LEN_W:0] CRC_ADD  = (LEN_W+1)'(CRC_BYTES);
    localparam logic [LEN_W:0] PAGE_LIM = (LEN_W+1)'(PAGE_BYTES);

    always_comb begin
        if (len < LEN_W'(MIN_FRAME))
            stored = LEN_W'(MIN_FRAME);
        else
            stored = {len[LEN_W-1:1], 1'b0};
        count = {1'b0, stored} + OVERHEAD + (strip ? '0 : CRC_ADD);
        too_big = count > PAGE_LIM;
        status = '0;
        status[STAT_BIT_LONG] = len > LEN_W'(MAX_FRAME);
        status[STAT_BIT_ODD]  = len[0];
    end
endmodule

// File: rtl/rpw_byte_sel.sv
module rpw_byte_sel #(
    parameter int LEN_W = 12
) (
    input  rx_page_writer_pkg::rpw_state_t st,
    input  logic [LEN_W-1:0] cnt,
    input  logic [LEN_W-1:0] len_q,
    input  logic             short_q,
    input  logic             odd_long_q,
    input  logic [15:0]      status_q,
    input  logic [LEN_W:0]   count_q,
    input  logic [31:0]      crc_q,
    input  logic [7:0]       frame_byte,
    output logic [LEN_W-1:0] frame_idx,
    output logic [7:0]       byte_out
);
    import rx_page_writer_pkg::*;

    logic [15:0] count16;
    assign count16 = 16'(count_q);

    always_comb begin
        frame_idx = cnt;
        byte_out  = 8'h00;
        unique case (st)
            ST_HEAD: begin
                unique case (cnt[1:0])
                    2'd0: byte_out = status_q[7:0];
                    2'd1: byte_out = status_q[15:8];
                    2'd2: byte_out = count16[7:0];
                    default: byte_out = count16[15:8];
                endcase
            end
            ST_BODY: begin
                if (short_q && cnt >= len_q)
                    byte_out = 8'h00;
                else
                    byte_out = frame_byte;
            end
            ST_CRC: byte_out = 8'(crc_q >> {cnt[1:0], 3'b000});
            ST_TAIL: begin
                frame_idx = len_q - LEN_W'(1);
                if (cnt[0] == 1'b0)
                    byte_out = odd_long_q ? frame_byte : 8'h00;
                else
                    byte_out = odd_long_q ? CTRL_ODD : CTRL_EVEN;
            end
            default: byte_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/rx_page_writer.sv
module rx_page_writer #(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_FRAME  = 1518,
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              strip_crc,
    input  logic              rx_enable,
    input  logic              soft_reset,
    input  logic              page_ok,
    input  logic [31:0]       crc_value,
    output logic [LEN_W-1:0]  frame_idx,
    input  logic [7:0]        frame_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              done,
    output logic              drop
);
    import rx_page_writer_pkg::*;

    rpw_state_t st_q, st_d;
    logic [LEN_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] wa_q;
    logic [LEN_W-1:0]  len_q, stored_q;
    logic [LEN_W:0]    count_q;
    logic [15:0]       status_q;
    logic [31:0]       crc_q;
    logic              strip_q, short_q, odd_long_q;

    logic [LEN_W-1:0]  lay_stored;
    logic [LEN_W:0]    lay_count;
    logic [15:0]       lay_status;
    logic              lay_too_big;
    logic              refuse;

    rpw_layout #(
        .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
        .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)
    ) u_layout (
        .len(frame_len), .strip(strip_crc), .stored(lay_stored),
        .count(lay_count), .status(lay_status), .too_big(lay_too_big)
    );

    assign refuse = !rx_enable || soft_reset || !page_ok || lay_too_big;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = refuse ? ST_DROP : ST_HEAD;
            ST_HEAD: if (cnt_q == LEN_W'(HEAD_BYTES - 1)) st_d = ST_BODY;
            ST_BODY: if (cnt_q == stored_q - LEN_W'(1))
                         st_d = strip_q ? ST_TAIL : ST_CRC;
            ST_CRC:  if (cnt_q == LEN_W'(CRC_BYTES - 1)) st_d = ST_TAIL;
            ST_TAIL: if (cnt_q == LEN_W'(TAIL_BYTES - 1)) st_d = ST_FIN;
            ST_FIN:  st_d = ST_IDLE;
            ST_DROP: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            wa_q       <= '0;
            len_q      <= '0;
            stored_q   <= '0;
            count_q    <= '0;
            status_q   <= '0;
            crc_q      <= '0;
            strip_q    <= 1'b0;
            short_q    <= 1'b0;
            odd_long_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_d != st_q) ? '0 : cnt_q + LEN_W'(1);
            if (st_q == ST_IDLE) begin
                wa_q <= '0;
                if (start && !refuse) begin
                    len_q      <= frame_len;
                    stored_q   <= lay_stored;
                    count_q    <= lay_count;
                    status_q   <= lay_status;
                    crc_q      <= crc_value;
                    strip_q    <= strip_crc;
                    short_q    <= frame_len < LEN_W'(MIN_FRAME);
                    odd_long_q <= frame_len[0] && frame_len >= LEN_W'(MIN_FRAME);
                end
            end else if (wr_en) begin
                wa_q <= wa_q + ADDR_W'(1);
            end
        end
    end

    rpw_byte_sel #(.LEN_W(LEN_W)) u_sel (
        .st(st_q), .cnt(cnt_q), .len_q(len_q), .short_q(short_q),
        .odd_long_q(odd_long_q), .status_q(status_q), .count_q(count_q),
        .crc_q(crc_q), .frame_byte(frame_byte), .frame_idx(frame_idx),
        .byte_out(wr_data)
    );

    always_comb begin
        wr_en = 1'b0;
        done  = 1'b0;
        drop  = 1'b0;
        unique case (st_q)
            ST_HEAD, ST_BODY, ST_CRC, ST_TAIL: wr_en = 1'b1;
            ST_FIN:  done = 1'b1;
            ST_DROP: drop = 1'b1;
            default: ;
        endcase
    end

    assign wr_addr = wa_q;
    assign busy    = st_q != ST_IDLE;

    p_refuse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (!rx_enable || soft_reset)) |=> drop);
    p_drop_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> !wr_en);
    p_nopage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !page_ok) |=> drop);
    p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + ADDR_W'(1));
    p_first_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> wr_addr == '0);
    p_done_after_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && ($past(wr_data) == CTRL_EVEN || $past(wr_data) == CTRL_ODD)));
    p_mutex_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && drop));
endmodule

// File: tb/rx_page_writer_bench.sv
module rx_page_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] frame_len = '0;
    logic        strip_crc = 1'b0;
    logic        rx_enable = 1'b0;
    logic        soft_reset = 1'b0;
    logic        page_ok = 1'b0;
    logic [31:0] crc_value = '0;
    logic [11:0] frame_idx;
    logic [7:0]  frame_byte;
    logic        wr_en, busy, done, drop;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;

    logic [7:0] frm [0:4095];
    logic [7:0] mem [0:2047];
    logic [7:0] expv [0:2047];
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;
    assign frame_byte = frm[frame_idx];

    rx_page_writer u_rx_page_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .strip_crc(strip_crc), .rx_enable(rx_enable), .soft_reset(soft_reset),
        .page_ok(page_ok), .crc_value(crc_value), .frame_idx(frame_idx),
        .frame_byte(frame_byte), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done), .drop(drop)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int build_exp(input int len, input bit strip, input logic [31:0] crc);
        int st, stored, cnt, p;
        st = (len > 1518 ? 32'h800 : 0) | ((len & 1) != 0 ? 32'h1000 : 0);
        stored = (len < 64) ? 64 : (len & ~1);
        cnt = stored + 6 + (strip ? 0 : 4);
        if (cnt > 2048) return cnt;
        expv[0] = st[7:0]; expv[1] = st[15:8];
        expv[2] = cnt[7:0]; expv[3] = cnt[15:8];
        for (int i = 0; i < stored; i++)
            expv[4+i] = (len < 64 && i >= len) ? 8'h00 : frm[i];
        p = 4 + stored;
        if (!strip) begin
            for (int k = 0; k < 4; k++) expv[p+k] = crc[8*k +: 8];
            p = p + 4;
        end
        if (len >= 64 && (len & 1) != 0) begin
            expv[p] = frm[len-1]; expv[p+1] = 8'h60;
        end else begin
            expv[p] = 8'h00; expv[p+1] = 8'h40;
        end
        return cnt;
    endfunction

    // compares expv vs mem over [lo,hi), one check
    task automatic cmp_range(input int lo, input int hi, input string req);
        int bad_at;
        bad_at = -1;
        for (int i = lo; i < hi; i++)
            if (bad_at < 0 && mem[i] !== expv[i]) bad_at = i;
        if (bad_at < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(mem[bad_at]), int'(expv[bad_at]));
    endtask

    task automatic run_frame(input int len, input bit strip, input bit en,
                             input bit srst, input bit pg, input logic [31:0] crc,
                             input string drop_req);
        int cnt, t, nwr, stored, p;
        bit exp_drop, bad_seq, both;
        for (int i = 0; i < 4096; i++) frm[i] = 8'($urandom);
        for (int i = 0; i < 2048; i++) mem[i] = 8'hxx;
        cnt = build_exp(len, strip, crc);
        exp_drop = !en || srst || !pg || cnt > 2048;
        @(negedge clk);
        start = 1'b1; frame_len = 12'(len); strip_crc = strip;
        rx_enable = en; soft_reset = srst; page_ok = pg; crc_value = crc;
        @(negedge clk);
        start = 1'b0;
        t = 1; nwr = 0; bad_seq = 1'b0; both = 1'b0;
        forever begin
            if (done && drop) both = 1'b1;
            if (wr_en) begin
                if (int'(wr_addr) != nwr) bad_seq = 1'b1;
                mem[wr_addr] = wr_data;
                nwr++;
            end
            if (done || drop) break;
            t++;
            if (t > 6000) begin
                chk(1'b0, "watchdog", t, 0);
                break;
            end
            @(negedge clk);
        end
        chk(!both, "R11 done/drop exclusive", int'(both), 0);
        if (exp_drop) begin
            chk(drop && t == 1, drop_req, t, 1);
            chk(nwr == 0, {drop_req, " no writes"}, nwr, 0);
        end else begin
            stored = (len < 64) ? 64 : (len & ~1);
            chk(done && t == cnt + 1, "R10 done timing", t, cnt + 1);
            chk(nwr == cnt && !bad_seq, "R10 write count/order", nwr, cnt);
            cmp_range(0, 2, "R4 status");
            cmp_range(2, 4, "R5 count");
            cmp_range(4, 4 + stored, len < 64 ? "R6 short pad" : "R7 payload");
            p = 4 + stored;
            if (!strip) begin
                cmp_range(p, p + 4, "R8 crc");
                p = p + 4;
            end
            cmp_range(p, p + 2, "R9 tail");
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!busy && !done && !drop && !wr_en, "R11 reset idle",
            {busy, done, drop, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wr_en, "R11 idle after reset", int'(busy), 0);

        // directed boundaries
        run_frame(63,   0, 1, 0, 1, 32'hA1B2C3D4, "R2");
        run_frame(63,   1, 1, 0, 1, 32'h0,        "R2");
        run_frame(64,   0, 1, 0, 1, 32'h11223344, "R2");
        run_frame(65,   0, 1, 0, 1, 32'hDEADBEEF, "R2");
        run_frame(65,   1, 1, 0, 1, 32'h0,        "R2");
        run_frame(1,    0, 1, 0, 1, 32'h01020304, "R2");
        run_frame(0,    1, 1, 0, 1, 32'h0,        "R2");
        run_frame(1518, 0, 1, 0, 1, 32'hCAFEF00D, "R2");
        run_frame(1519, 0, 1, 0, 1, 32'h87654321, "R2");
        run_frame(2039, 0, 1, 0, 1, 32'h55AA55AA, "R2");
        run_frame(2040, 0, 1, 0, 1, 32'h0,        "R2 too big with crc");
        run_frame(2043, 1, 1, 0, 1, 32'h0,        "R2");
        run_frame(2044, 1, 1, 0, 1, 32'h0,        "R2 too big stripped");
        run_frame(100,  0, 0, 0, 1, 32'h0,        "R1 rx disabled");
        run_frame(100,  0, 1, 1, 1, 32'h0,        "R1 soft reset");
        run_frame(100,  0, 1, 0, 0, 32'h0,        "R3 no page");

        // constrained random
        for (int n = 0; n < 40; n++) begin
            int len;
            int sel;
            sel = int'($urandom % 4);
            if (sel == 0) len = int'($urandom % 64);
            else if (sel == 1) len = 64 + int'($urandom % 200);
            else if (sel == 2) len = 1500 + int'($urandom % 40);
            else len = 2030 + int'($urandom % 20);
            run_frame(len, 1'($urandom), 1'b1, 1'b0,
                      ($urandom % 8) != 0, $urandom, "R2/R3 random drop");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #900000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule